// File: doc/BRIEF.md
# Output-Buffered Source-Routed Packet Switch

This block is a switch for an on-chip packet network. It has NUM_PORTS input ports and NUM_PORTS output ports joined by a full crossbar, so any input can reach any output. Packets travel as a series of flits. The first flit of a packet carries the whole path the packet will take, written as a list of output-port indices. The switch reads the index for its own hop from the bottom of that list. It then shifts the list down so that the next switch finds its own index at the bottom.

Each output port has its own round-robin arbiter, a register stage and a FIFO. Once an input wins an output, it keeps that output until the last flit of its packet has passed. Inputs that lose are stalled. An input is also stalled when the FIFO it targets has no free slot. A build-time mask sets which inputs are allowed to compete for each output.

Top module: `nsw_switch`

## Requirements
- R1: While reset is held, every out_valid bit is 0. Right after reset, every in_stall bit is 1 until an input presents a flit that can be taken.
- R2: A flit occupies bits [PAYLOAD_W+1:0], with the kind in the top two bits: 01 opens a packet, 00 continues it, 10 closes it, 11 is a one-flit packet. On a flit of kind 01 or 11, the route is payload bits [ROUTE_W-1:0]. The low log2(NUM_PORTS) bits of the route select the output port. The flit leaves with its route shifted right by log2(NUM_PORTS) bits and zero-filled at the top. Its kind and the payload bits above the route are unchanged.
- R3: Flits of kind 00 and 10 go to the output chosen by the opening flit of their packet, without any change and in the order they arrived.
- R4: A flit accepted at clock edge t (in_valid high and in_stall low) appears on out_valid no earlier than edge t+2. It appears exactly there when the output FIFO is empty and out_stall is low.
- R5: When an output is free, the opening flits that want it are served in round-robin order. The search starts at a pointer and rises by index, wrapping around. The pointer is 0 after reset. When a packet from input i closes, the pointer becomes (i+1) mod NUM_PORTS.
- R6: Once an opening flit of kind 01 is accepted, its output serves only that input until the input's closing flit is accepted. Every other input that wants that output is stalled. An input that is not presenting a flit is always stalled.
- R7: While out_stall is high, out_valid and out_flit on that port hold their values. An output accepts at most FIFO_DEPTH flits, counting the flit in its register stage, before it stalls its inputs. No flit is lost or duplicated, and order is kept.
- R8: If bit o*NUM_PORTS+i of SRC_ALLOW is 0, input i is never granted output o and stays stalled while it asks for it. Other inputs still reach output o.
- R9: Packets from different inputs to different outputs are accepted in the same cycle and do not delay each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_PORTS | A flit is offered on each input |
| in_flit | input | NUM_PORTS*(PAYLOAD_W+2) | Input flits, port i at slice i |
| in_stall | output | NUM_PORTS | Flit on the input is not taken this cycle |
| out_valid | output | NUM_PORTS | A flit is presented on each output |
| out_flit | output | NUM_PORTS*(PAYLOAD_W+2) | Output flits, port o at slice o |
| out_stall | input | NUM_PORTS | The downstream side cannot take the output flit |

## Verification
First, one-flit packets are sent from every input to a range of outputs. This separates correct port selection and route shifting from mistakes in bit position, and checks the two-cycle arrival. Several multi-flit packets are then sent from different inputs to one output. The order of grants shows whether the pointer moves only when a packet closes, and the stalls on the losing inputs show that the lock holds. A stalled output that fills up tells whether the register stage is counted in the free space and whether every flit comes out in order. Four packets sent at once to four different outputs, and a second instance with a restricted mask, tell apart crossbar blocking and mask handling from correct behaviour.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

  // Flit kind field, top two bits of every flit
  typedef enum logic [1:0] {
    FK_MID   = 2'b00,
    FK_OPEN  = 2'b01,
    FK_CLOSE = 2'b10,
    FK_SOLO  = 2'b11
  } flit_kind_e;

  // A flit of this kind carries a route and starts a packet
  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  // A flit of this kind ends a packet and releases the output
  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/nsw_fifo.sv
module nsw_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rd_data,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_pop;

  assign do_pop = pop && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage holds data only; no reset needed
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign rd_data = mem[rd_ptr_q];
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;

endmodule

// File: rtl/nsw_rr_arb.sv
module nsw_rr_arb #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0]         req,
  input  logic [$clog2(NUM_PORTS)-1:0] ptr,
  output logic [NUM_PORTS-1:0]         gnt
);

  // First requester at or above ptr, wrapping past the top index
  always_comb begin
    int   cand;
    logic found;
    gnt   = '0;
    found = 1'b0;
    cand  = 0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      cand = int'(ptr) + k;
      if (cand >= NUM_PORTS) begin
        cand = cand - NUM_PORTS;
      end
      if (!found && req[cand]) begin
        gnt[cand] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nsw_in_route.sv
module nsw_in_route #(
  parameter int NUM_PORTS = 4,
  parameter int PAYLOAD_W = 16,
  parameter int ROUTE_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           valid,
  input  logic [PAYLOAD_W+1:0]           flit,
  input  logic                           taken,
  output logic [NUM_PORTS-1:0]           req_oh,
  output logic                           opens,
  output logic                           closes,
  output logic [PAYLOAD_W+1:0]           fwd_flit
);

  import nsw_pkg::*;

  localparam int IDX_W  = $clog2(NUM_PORTS);
  localparam int FLIT_W = PAYLOAD_W + 2;

  logic [1:0]         kind;
  logic [ROUTE_W-1:0] route;
  logic [IDX_W-1:0]   dest_q, dest_d, dest_sel;

  assign kind   = flit[FLIT_W-1 -: 2];
  assign route  = flit[ROUTE_W-1:0];
  assign opens  = kind_opens(kind);
  assign closes = kind_closes(kind);

  // Opening flits name their own port; the rest follow the stored one
  assign dest_sel = opens ? route[IDX_W-1:0] : dest_q;

  always_comb begin
    for (int k = 0; k < NUM_PORTS; k++) begin
      req_oh[k] = valid && (dest_sel == IDX_W'(k));
    end
  end

  // Consume this hop's index from the route before forwarding
  assign fwd_flit = opens ? {kind, flit[PAYLOAD_W-1:ROUTE_W], route >> IDX_W}
                          : flit;

  assign dest_d = (taken && opens) ? route[IDX_W-1:0] : dest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else begin
      dest_q <= dest_d;
    end
  end

endmodule

// File: rtl/nsw_out_port.sv
module nsw_out_port #(
  parameter int NUM_PORTS  = 4,
  parameter int FLIT_W     = 18,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req,
  input  logic [NUM_PORTS-1:0]        opens,
  input  logic [NUM_PORTS-1:0]        closes,
  input  logic [NUM_PORTS*FLIT_W-1:0] flits,
  input  logic                        out_stall,
  output logic [NUM_PORTS-1:0]        acc,
  output logic                        out_valid,
  output logic [FLIT_W-1:0]           out_flit
);

  localparam int IDX_W = $clog2(NUM_PORTS);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     owner_q, owner_d;
  logic [IDX_W-1:0]     ptr_q, ptr_d;
  logic                 stage_v_q, stage_v_d;
  logic [FLIT_W-1:0]    stage_flit_q, stage_flit_d;

  logic [NUM_PORTS-1:0] rr_gnt, owner_pick, pick;
  logic [CNT_W-1:0]     fifo_count;
  logic [CNT_W:0]       used_slots;
  logic                 space, fifo_empty;
  logic                 acc_any, sel_open, sel_close;
  logic [IDX_W-1:0]     acc_idx;
  logic [FLIT_W-1:0]    sel_flit;

  // Only opening flits may start a new grant
  nsw_rr_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .req (req & opens),
    .ptr (ptr_q),
    .gnt (rr_gnt)
  );

  always_comb begin
    for (int k = 0; k < NUM_PORTS; k++) begin
      owner_pick[k] = req[k] && (owner_q == IDX_W'(k));
    end
  end

  assign pick = busy_q ? owner_pick : rr_gnt;

  // The flit in the register stage already owns a FIFO slot
  assign used_slots = {1'b0, fifo_count} + (CNT_W+1)'(stage_v_q);
  assign space      = used_slots < (CNT_W+1)'(FIFO_DEPTH);
  assign acc        = space ? pick : '0;
  assign acc_any    = |acc;

  // Crossbar column for this output
  always_comb begin
    sel_flit  = '0;
    acc_idx   = '0;
    sel_open  = 1'b0;
    sel_close = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (acc[k]) begin
        sel_flit  = flits[k*FLIT_W +: FLIT_W];
        acc_idx   = IDX_W'(k);
        sel_open  = opens[k];
        sel_close = closes[k];
      end
    end
  end

  always_comb begin
    busy_d       = busy_q;
    owner_d      = owner_q;
    ptr_d        = ptr_q;
    stage_v_d    = acc_any;
    stage_flit_d = stage_flit_q;
    if (acc_any) begin
      stage_flit_d = sel_flit;
      if (sel_open) begin
        owner_d = acc_idx;
      end
      if (sel_close) begin
        busy_d = 1'b0;
        ptr_d  = (acc_idx == IDX_W'(NUM_PORTS - 1)) ? '0 : acc_idx + 1'b1;
      end else if (sel_open) begin
        busy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      owner_q   <= '0;
      ptr_q     <= '0;
      stage_v_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      owner_q   <= owner_d;
      ptr_q     <= ptr_d;
      stage_v_q <= stage_v_d;
    end
  end

  // Stage data has a clock enable, no reset
  always_ff @(posedge clk) begin
    if (acc_any) begin
      stage_flit_q <= stage_flit_d;
    end
  end

  nsw_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stage_v_q),
    .push_data (stage_flit_q),
    .pop       (!fifo_empty && !out_stall),
    .rd_data   (out_flit),
    .empty     (fifo_empty),
    .count     (fifo_count)
  );

  assign out_valid = !fifo_empty;

endmodule

// File: rtl/nsw_switch.sv
module nsw_switch #(
  parameter int                               NUM_PORTS  = 4,
  parameter int                               PAYLOAD_W  = 16,
  parameter int                               ROUTE_W    = 8,
  parameter int                               FIFO_DEPTH = 4,
  parameter logic [NUM_PORTS*NUM_PORTS-1:0]   SRC_ALLOW  = '1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 in_valid,
  input  logic [NUM_PORTS*(PAYLOAD_W+2)-1:0]   in_flit,
  output logic [NUM_PORTS-1:0]                 in_stall,
  output logic [NUM_PORTS-1:0]                 out_valid,
  output logic [NUM_PORTS*(PAYLOAD_W+2)-1:0]   out_flit,
  input  logic [NUM_PORTS-1:0]                 out_stall
);

  localparam int FLIT_W = PAYLOAD_W + 2;

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] in_req;   // [input][output]
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_m;    // [output][input]
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] acc_m;    // [output][input]
  logic [NUM_PORTS-1:0]                opens_v, closes_v, taken_v;
  logic [NUM_PORTS*FLIT_W-1:0]         fwd_bus;

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
    nsw_in_route #(
      .NUM_PORTS (NUM_PORTS),
      .PAYLOAD_W (PAYLOAD_W),
      .ROUTE_W   (ROUTE_W)
    ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (in_valid[gi]),
      .flit     (in_flit[gi*FLIT_W +: FLIT_W]),
      .taken    (taken_v[gi]),
      .req_oh   (in_req[gi]),
      .opens    (opens_v[gi]),
      .closes   (closes_v[gi]),
      .fwd_flit (fwd_bus[gi*FLIT_W +: FLIT_W])
    );
  end

  // Transpose requests and apply the build-time source mask
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        req_m[o][i] = in_req[i][o] && SRC_ALLOW[o*NUM_PORTS + i];
      end
    end
  end

  for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
    nsw_out_port #(
      .NUM_PORTS  (NUM_PORTS),
      .FLIT_W     (FLIT_W),
      .FIFO_DEPTH (FIFO_DEPTH)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_m[go]),
      .opens     (opens_v),
      .closes    (closes_v),
      .flits     (fwd_bus),
      .out_stall (out_stall[go]),
      .acc       (acc_m[go]),
      .out_valid (out_valid[go]),
      .out_flit  (out_flit[go*FLIT_W +: FLIT_W])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      taken_v[i] = 1'b0;
      for (int o = 0; o < NUM_PORTS; o++) begin
        taken_v[i] = taken_v[i] | acc_m[o][i];
      end
    end
  end

  assign in_stall = ~taken_v;

endmodule

// File: rtl/nsw_switch_chk.sv
module nsw_switch_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PAYLOAD_W = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_PORTS-1:0]               in_valid,
  input logic [NUM_PORTS-1:0]               in_stall,
  input logic [NUM_PORTS-1:0]               out_valid,
  input logic [NUM_PORTS*(PAYLOAD_W+2)-1:0] out_flit,
  input logic [NUM_PORTS-1:0]               out_stall
);

  localparam int FLIT_W = PAYLOAD_W + 2;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (out_valid == '0);
    end
  end

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in_chk
    // R6
    idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[gi] |-> in_stall[gi]);

    // R4
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[gi] && !in_stall[gi]) |-> ##2 (|out_valid));
  end

  for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out_chk
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && out_stall[go]) |=>
        (out_valid[go] && $stable(out_flit[go*FLIT_W +: FLIT_W])));
  end

endmodule

bind nsw_switch nsw_switch_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PAYLOAD_W (PAYLOAD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_stall  (in_stall),
  .out_valid (out_valid),
  .out_flit  (out_flit),
  .out_stall (out_stall)
);

// File: tb/nsw_switch_tb.sv
`timescale 1ns/1ps
module nsw_switch_tb;

  localparam int N  = 4;
  localparam int PW = 16;
  localparam int FW = PW + 2;

  typedef struct packed {
    logic [1:0]  src;
    logic [15:0] pl;
    logic [1:0]  dst;
    logic [15:0] exp_pl;
  } vec_t;

  // One-flit packets: source, payload with route, expected port, expected payload
  localparam vec_t VECS [6] = '{
    '{2'd0, 16'h12E4, 2'd0, 16'h1239},
    '{2'd1, 16'h3401, 2'd1, 16'h3400},
    '{2'd2, 16'h56FE, 2'd2, 16'h563F},
    '{2'd3, 16'h78C7, 2'd3, 16'h7831},
    '{2'd0, 16'h9A1B, 2'd3, 16'h9A06},
    '{2'd3, 16'hBC82, 2'd2, 16'hBC20}
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  in_valid, in_stall, out_valid, out_stall;
  logic [N*FW-1:0] in_flit, out_flit;
  logic [N-1:0]  m_in_valid, m_in_stall, m_out_valid, m_out_stall;
  logic [N*FW-1:0] m_in_flit, m_out_flit;

  int tests, fails;
  bit done;
  logic [FW-1:0] cap [N][16];
  int cap_n [N];

  nsw_switch #(.NUM_PORTS(N), .PAYLOAD_W(PW), .ROUTE_W(8), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_stall(in_stall), .out_valid(out_valid), .out_flit(out_flit),
    .out_stall(out_stall)
  );

  // Input 1 may not use output 0
  nsw_switch #(.NUM_PORTS(N), .PAYLOAD_W(PW), .ROUTE_W(8), .FIFO_DEPTH(4),
               .SRC_ALLOW(16'hFFFD)) u_dut_mask (
    .clk(clk), .rst_n(rst_n), .in_valid(m_in_valid), .in_flit(m_in_flit),
    .in_stall(m_in_stall), .out_valid(m_out_valid), .out_flit(m_out_flit),
    .out_stall(m_out_stall)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int p = 0; p < N; p++) begin
        if (out_valid[p] && !out_stall[p]) begin
          if (cap_n[p] < 16) cap[p][cap_n[p]] = out_flit[p*FW +: FW];
          cap_n[p]++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_in(input int i, input logic v, input logic [FW-1:0] f);
    in_valid[i]         = v;
    in_flit[i*FW +: FW] = f;
  endtask

  task automatic set_m(input int i, input logic v, input logic [FW-1:0] f);
    m_in_valid[i]         = v;
    m_in_flit[i*FW +: FW] = f;
  endtask

  task automatic clear_cap();
    for (int p = 0; p < N; p++) cap_n[p] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0; in_flit = '0; out_stall = '0;
    m_in_valid = '0; m_in_flit = '0; m_out_stall = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_cap();
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    in_valid = '0; in_flit = '0; out_stall = '0;
    m_in_valid = '0; m_in_flit = '0; m_out_stall = '0;
    clear_cap();
    repeat (2) @(negedge clk);
    #1;
    chk("R1 out_valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 in_stall after reset", 32'(in_stall), 32'hF);
    chk("R1 out_valid after reset", 32'(out_valid), 32'h0);

    // Table walk: R2 routing and route shift, R4 two-cycle arrival
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      set_in(VECS[v].src, 1'b1, {2'b11, VECS[v].pl});
      #1;
      chk("R4 taken when free", 32'(in_stall[VECS[v].src]), 32'h0);
      @(negedge clk);
      set_in(VECS[v].src, 1'b0, '0);
      #1;
      chk("R4 not before two cycles", 32'(out_valid), 32'h0);
      @(negedge clk);
      #1;
      chk("R4 arrival port", 32'(out_valid), 32'(1 << VECS[v].dst));
      chk("R2 forwarded flit", 32'(out_flit[VECS[v].dst*FW +: FW]),
          32'({2'b11, VECS[v].exp_pl}));
    end
    @(negedge clk);

    // R5 / R6: contention on output 3
    do_reset();
    @(negedge clk);
    set_in(1, 1'b1, {2'b01, 16'hA103});
    set_in(2, 1'b1, {2'b11, 16'hB20F});
    #1;
    chk("R5 pointer 0 picks input 1", 32'(in_stall[2:1]), 32'b10);
    @(negedge clk);
    set_in(1, 1'b1, {2'b00, 16'hA1B0});
    #1;
    chk("R6 lock holds on body", 32'(in_stall[2:1]), 32'b10);
    @(negedge clk);
    set_in(1, 1'b1, {2'b10, 16'hA1C0});
    #1;
    chk("R6 lock holds on tail", 32'(in_stall[2:1]), 32'b10);
    @(negedge clk);
    set_in(1, 1'b1, {2'b01, 16'hD123});
    #1;
    chk("R5 pointer moved past input 1", 32'(in_stall[2:1]), 32'b01);
    @(negedge clk);
    set_in(2, 1'b0, '0);
    set_in(0, 1'b1, {2'b11, 16'hC0FF});
    #1;
    chk("R5 wrap picks input 0", 32'({in_stall[1], in_stall[0]}), 32'b10);
    @(negedge clk);
    set_in(0, 1'b0, '0);
    #1;
    chk("R5 input 1 served last", 32'(in_stall[1]), 32'h0);
    @(negedge clk);
    set_in(1, 1'b1, {2'b10, 16'hD1EE});
    #1;
    chk("R6 owner tail taken", 32'(in_stall[1]), 32'h0);
    @(negedge clk);
    set_in(1, 1'b0, '0);
    repeat (5) @(negedge clk);
    chk("R3 packet count on port 3", 32'(cap_n[3]), 32'd7);
    chk("R3 flit 0", 32'(cap[3][0]), 32'({2'b01, 16'hA100}));
    chk("R3 body unchanged", 32'(cap[3][1]), 32'({2'b00, 16'hA1B0}));
    chk("R3 tail unchanged", 32'(cap[3][2]), 32'({2'b10, 16'hA1C0}));
    chk("R5 order flit 3", 32'(cap[3][3]), 32'({2'b11, 16'hB203}));
    chk("R5 order flit 4", 32'(cap[3][4]), 32'({2'b11, 16'hC03F}));
    chk("R2 second head shifted", 32'(cap[3][5]), 32'({2'b01, 16'hD108}));
    chk("R3 second tail", 32'(cap[3][6]), 32'({2'b10, 16'hD1EE}));
    chk("R3 no stray output", 32'(cap_n[0] + cap_n[1] + cap_n[2]), 32'd0);

    // R7: backpressure on output 0
    do_reset();
    out_stall[0] = 1'b1;
    begin
      int sent = 0;
      for (int cyc = 0; cyc < 30; cyc++) begin
        @(negedge clk);
        if (cyc == 10) out_stall[0] = 1'b0;
        if (sent < 6) set_in(0, 1'b1, {2'b11, 8'(8'h50 + sent), 8'h04});
        else set_in(0, 1'b0, '0);
        #1;
        if (cyc == 9) begin
          chk("R7 accepted before full", 32'(sent), 32'd4);
          chk("R7 stalled when full", 32'(in_stall[0]), 32'h1);
          chk("R7 head held under stall", 32'(out_flit[FW-1:0]),
              32'({2'b11, 8'h50, 8'h01}));
          chk("R7 valid held under stall", 32'(out_valid[0]), 32'h1);
        end
        if (in_valid[0] && !in_stall[0]) sent++;
      end
      chk("R7 all flits taken", 32'(sent), 32'd6);
    end
    chk("R7 no loss or duplicate", 32'(cap_n[0]), 32'd6);
    for (int k = 0; k < 6; k++) begin
      chk("R7 order kept", 32'(cap[0][k]), 32'({2'b11, 8'(8'h50 + k), 8'h01}));
    end

    // R9: four disjoint transfers in one cycle
    do_reset();
    @(negedge clk);
    set_in(0, 1'b1, {2'b11, 16'h0101});
    set_in(1, 1'b1, {2'b11, 16'h1100});
    set_in(2, 1'b1, {2'b11, 16'h2203});
    set_in(3, 1'b1, {2'b11, 16'h3302});
    #1;
    chk("R9 all inputs taken", 32'(in_stall), 32'h0);
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    #1;
    chk("R9 all outputs valid", 32'(out_valid), 32'hF);
    chk("R9 port 0", 32'(out_flit[0*FW +: FW]), 32'({2'b11, 16'h1100}));
    chk("R9 port 1", 32'(out_flit[1*FW +: FW]), 32'({2'b11, 16'h0100}));
    chk("R9 port 2", 32'(out_flit[2*FW +: FW]), 32'({2'b11, 16'h3300}));
    chk("R9 port 3", 32'(out_flit[3*FW +: FW]), 32'({2'b11, 16'h2200}));

    // R8: masked source on the second instance
    do_reset();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      set_m(1, 1'b1, {2'b11, 16'h4400});
      #1;
      chk("R8 masked input stalled", 32'(m_in_stall[1]), 32'h1);
    end
    #1;
    chk("R8 nothing on output 0", 32'(m_out_valid), 32'h0);
    @(negedge clk);
    set_m(1, 1'b0, '0);
    set_m(2, 1'b1, {2'b11, 16'h4500});
    #1;
    chk("R8 allowed input taken", 32'(m_in_stall[2]), 32'h0);
    @(negedge clk);
    set_m(2, 1'b0, '0);
    @(negedge clk);
    #1;
    chk("R8 allowed flit arrives", 32'(m_out_valid), 32'h1);
    chk("R8 allowed flit value", 32'(m_out_flit[FW-1:0]), 32'({2'b11, 16'h4500}));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule